// File: doc/BRIEF.md
# Oversampled I2C Slave Output Expander

This block is an I2C slave that works entirely on a fast system clock. SCL is never used as a clock and there is no combinational feedback. Each bus line goes through a two-flop synchroniser and a saturating-count glitch filter. START and STOP conditions are found by comparing the filtered lines with their values one clock earlier. The slave holds one 8-bit register. A bus master can overwrite it or read it back, and the register drives an 8-bit output port for general-purpose use.

The slave answers a single 7-bit address set by a parameter. It never drives SDA high. It only asserts an open-drain pull-low enable, and the pad outside the block turns that into a low level on the wire. Clock stretching, register sub-addressing, 10-bit addressing and general call are not supported.

Top module: `i2cExpander`

## Requirements
- R1: Reset releases SDA (sdaPullLow = 0), clears ioOut to 0x00 and leaves the slave idle until the next START.
- R2: A pulse on SCL or SDA shorter than FILT_LEN oversampled clocks is ignored. A level change on either line reaches the protocol logic 2 + FILT_LEN clocks after it appears at the pin.
- R3: A START is a falling SDA while SCL is high. The first SCL fall after it ends the START. Each following byte is 8 data bits, most significant first, sampled on SCL rising edges, plus a ninth acknowledge clock.
- R4: The address is compared one bit at a time against OWN_ADDR (default 7'h27). One mismatching bit stops the slave from acknowledging, storing or driving until the next START or STOP.
- R5: After a matching address byte (read bit = 1 or write bit = 0), the slave pulls SDA low for the whole ninth clock.
- R6: On a write, each data byte is stored in the register and acknowledged. When several bytes are sent, the last one wins. ioOut takes the new value at the SCL fall that ends the eighth data bit.
- R7: On a read, the slave sends the register MSB first. It pulls SDA low for a 0 and releases it for a 1, and it sends the same register for every byte. It releases SDA during the master's acknowledge clock.
- R8: If the master does not acknowledge a read byte, the slave keeps SDA released for the rest of the transaction.
- R9: A STOP (rising SDA while SCL is high) or a repeated START resets the bit count and the address match, even in the middle of a byte.
- R10: sdaPullLow changes only 3 + FILT_LEN clocks after a SCL fall at the pin, or when SDA is released because of a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | SCL line as seen at the pin |
| sdaIn | input | 1 | SDA line as seen at the pin |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls SDA to ground |
| ioOut | output | 8 | Contents of the slave register |

## Verification
Every result of this block comes a fixed number of clocks after a line change at the pins. A filtered level appears 2 + FILT_LEN clocks after the pin changes. sdaPullLow and ioOut move one clock later than that, on the clock that acts on the filtered SCL fall. The bench reference model keeps its own history of the intended, glitch-free line levels and reads it at exactly that depth. It compares both outputs with the model at every falling clock edge, half a cycle after the registers update. On top of that, the master tasks check the byte-level results: the acknowledge bits and the read-back values they sample at the middle of SCL high, and ioOut once each transfer is over.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BUSY  = 2'd2
  } phase_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic       txnReset;   // START or STOP seen
    logic       sampleBit;  // SCL rose on a data bit
    logic       addrBit;    // that bit is one of the 7 address bits
    logic [2:0] addrIdx;    // address bit index to compare
    logic       ackSample;  // SCL rose in the acknowledge slot
    logic       memLoad;    // write byte complete
    logic       driveUpd;   // SCL fell: recompute SDA drive
    logic       driveAck;   // next slot is an ack the slave gives
    logic       driveData;  // next slot is a read data bit
    logic [2:0] txIdx;      // register bit for the next read slot
  } ctlStrobes_t;

endpackage

// File: rtl/i2cxGlitchFilter.sv
module i2cxGlitchFilter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [CW-1:0]          runCnt;
  logic                   filtQ;

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign lineOut = filtQ;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      filtQ  <= 1'b1;
      runCnt <= '0;
    end else if (syncOut == filtQ) begin
      runCnt <= '0;
    end else if (runCnt == CW'(FILT_LEN - 1)) begin
      filtQ  <= syncOut;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R2: the run counter never passes the filter length
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
    runCnt < CW'(FILT_LEN));

  // R2: a filtered change always follows a differing synchronised sample
  a_r2_change_follows_input: assert property (@(posedge clk) disable iff (rst)
    (filtQ != $past(filtQ)) |-> ($past(syncOut) == filtQ));
endmodule

// File: rtl/i2cxControl.sv
module i2cxControl
  import i2cx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sclF,
  input  logic        sdaF,
  output ctlStrobes_t st
);
  logic   sclPrev, sdaPrev;
  phase_e phase;
  logic [3:0] bitPos;     // 0..7 data, 8 = acknowledge slot
  logic   dataPh;
  logic   readOp;

  logic sclRise, sclFall, startC, stopC, busy, ackSlot, lastData, nextData;
  logic [3:0] nextPos;

  always_comb begin
    sclRise  = sclF & ~sclPrev;
    sclFall  = ~sclF & sclPrev;
    startC   = sclF & sclPrev & sdaPrev & ~sdaF;
    stopC    = sclF & sclPrev & ~sdaPrev & sdaF;
    busy     = (phase == PH_BUSY);
    ackSlot  = (bitPos == 4'd8);
    lastData = (bitPos == 4'd7);
    nextPos  = ackSlot ? 4'd0 : 4'(bitPos + 4'd1);
    nextData = ackSlot | dataPh;

    st          = '0;
    st.txnReset = startC | stopC;
    if (!st.txnReset && busy && sclRise) begin
      st.sampleBit = ~ackSlot;
      st.addrBit   = ~dataPh & (bitPos < 4'd7);
      st.addrIdx   = 3'(4'd6 - bitPos);
      st.ackSample = ackSlot;
    end
    if (!st.txnReset && busy && sclFall) begin
      st.memLoad   = lastData & dataPh & ~readOp;
      st.driveUpd  = 1'b1;
      st.driveAck  = (nextPos == 4'd8) & (~dataPh | ~readOp);
      st.driveData = (nextPos < 4'd8) & nextData & readOp;
      st.txIdx     = 3'(4'd7 - nextPos);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      bitPos <= '0;
      dataPh <= 1'b0;
      readOp <= 1'b0;
    end else if (startC || stopC) begin
      phase  <= startC ? PH_START : PH_IDLE;
      bitPos <= '0;
      dataPh <= 1'b0;
      readOp <= 1'b0;
    end else if (sclFall && phase == PH_START) begin
      phase <= PH_BUSY;
    end else if (busy && sclRise) begin
      if (~dataPh && lastData) readOp <= sdaF;
    end else if (busy && sclFall) begin
      bitPos <= nextPos;
      dataPh <= nextData;
    end
  end

  // R3: bit position stays within one byte plus the acknowledge slot
  a_r3_pos_range: assert property (@(posedge clk) disable iff (rst)
    bitPos <= 4'd8);

  // R9: a START or STOP leaves the byte framing at its origin
  a_r9_cond_clears: assert property (@(posedge clk) disable iff (rst)
    $past(st.txnReset) |-> (bitPos == 4'd0 && !dataPh && !readOp));
endmodule

// File: rtl/i2cxDatapath.sv
module i2cxDatapath
  import i2cx_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h27
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sdaF,
  input  ctlStrobes_t st,
  output logic        pullLow,
  output logic [7:0]  regOut
);
  logic [7:0] shiftQ, memQ;
  logic       matchQ, gotAckQ, pullQ;

  assign pullLow = pullQ;
  assign regOut  = memQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ  <= '0;
      memQ    <= '0;
      matchQ  <= 1'b1;
      gotAckQ <= 1'b1;
      pullQ   <= 1'b0;
    end else if (st.txnReset) begin
      matchQ  <= 1'b1;
      gotAckQ <= 1'b1;
      pullQ   <= 1'b0;
    end else begin
      if (st.sampleBit) shiftQ <= {shiftQ[6:0], sdaF};
      if (st.addrBit && (sdaF != OWN_ADDR[st.addrIdx])) matchQ <= 1'b0;
      if (st.ackSample) gotAckQ <= ~sdaF;
      if (st.memLoad && matchQ) memQ <= shiftQ;
      if (st.driveUpd)
        pullQ <= matchQ & (st.driveAck |
                           (st.driveData & gotAckQ & ~memQ[st.txIdx]));
    end
  end

  // R4: the match flag comes back only through a START or STOP
  a_r4_match_sticky: assert property (@(posedge clk) disable iff (rst)
    $rose(matchQ) |-> $past(st.txnReset));

  // R6: the register changes only on a completed write to this slave
  a_r6_mem_only_on_load: assert property (@(posedge clk) disable iff (rst)
    (memQ != $past(memQ)) |-> $past(st.memLoad && matchQ));

  // R8: after a missing master acknowledge, read slots stay released
  a_r8_nack_release: assert property (@(posedge clk) disable iff (rst)
    (st.driveUpd && st.driveData && !gotAckQ) |=> !pullQ);

  // R10: drive moves only on a SCL fall strobe or a bus condition
  a_r10_pull_timing: assert property (@(posedge clk) disable iff (rst)
    (pullQ != $past(pullQ)) |-> $past(st.driveUpd || st.txnReset));
endmodule

// File: rtl/i2cExpander.sv
module i2cExpander
  import i2cx_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h27,
  parameter int         FILT_LEN    = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic [7:0] ioOut
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLines, cleanLines;
  ctlStrobes_t        strobes;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < N_LINES; g++) begin : gLine
    i2cxGlitchFilter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) uFilt (
      .clk    (clk),
      .rst    (rst),
      .lineIn (rawLines[g]),
      .lineOut(cleanLines[g])
    );
  end

  i2cxControl uCtl (
    .clk (clk),
    .rst (rst),
    .sclF(cleanLines[1]),
    .sdaF(cleanLines[0]),
    .st  (strobes)
  );

  i2cxDatapath #(.OWN_ADDR(OWN_ADDR)) uDp (
    .clk    (clk),
    .rst    (rst),
    .sdaF   (cleanLines[0]),
    .st     (strobes),
    .pullLow(sdaPullLow),
    .regOut (ioOut)
  );
endmodule

// File: tb/i2cExpander_test.sv
module i2cExpander_test;
  localparam logic [6:0] ADDR = 7'h27;
  localparam int FL = 4;
  localparam int H  = 20;   // half SCL period in clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mScl = 1'b1, mSda = 1'b1, gScl = 1'b0, gSda = 1'b0;
  logic sdaPullLow;
  logic [7:0] ioOut;
  logic busSda;
  logic sclPin, sdaPin;

  always #10 clk = ~clk;   // 50 MHz

  assign busSda = mSda & ~sdaPullLow;
  assign sclPin = mScl ^ gScl;
  assign sdaPin = busSda ^ gSda;

  i2cExpander #(.OWN_ADDR(ADDR), .FILT_LEN(FL)) uut (
    .clk(clk), .rst(rst), .sclIn(sclPin), .sdaIn(sdaPin),
    .sdaPullLow(sdaPullLow), .ioOut(ioOut)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0] hist [0:15];
  int  mPhase, mPos, mRd, mMatch, mGotAck, mDataPh;
  logic [7:0] mShift, expIo;
  logic expPull;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) hist[i] = 2'b11;
      mPhase = 0; mPos = 0; mRd = 0; mMatch = 1; mGotAck = 1; mDataPh = 0;
      mShift = '0; expIo = '0; expPull = 1'b0;
    end else begin
      logic cS, cD, pS, pD;
      for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {mScl, mSda & ~expPull};
      {cS, cD} = hist[FL+2];
      {pS, pD} = hist[FL+3];
      if (cS && pS && pD != cD) begin
        mPhase = cD ? 0 : 1;
        mPos = 0; mDataPh = 0; mRd = 0; mMatch = 1; mGotAck = 1; expPull = 1'b0;
      end else if (mPhase == 2 && cS && !pS) begin
        if (mPos < 8) mShift = {mShift[6:0], cD};
        if (!mDataPh && mPos < 7 && cD != ADDR[6-mPos]) mMatch = 0;
        if (!mDataPh && mPos == 7) mRd = cD;
        if (mPos == 8) mGotAck = !cD;
      end else if (!cS && pS) begin
        if (mPhase == 1) mPhase = 2;
        else if (mPhase == 2) begin
          int np, nd;
          if (mPos == 7 && mDataPh && !mRd && mMatch) expIo = mShift;
          np = (mPos == 8) ? 0 : mPos + 1;
          nd = (mPos == 8) ? 1 : mDataPh;
          expPull = mMatch && ((np == 8 && (!mDataPh || !mRd)) ||
                               (np < 8 && nd && mRd && mGotAck && !expIo[7-np]));
          mPos = np; mDataPh = nd;
        end
      end
    end
  end

  // R10 / R1: per-clock comparison, half a cycle after the update edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 pull per-clock", sdaPullLow, expPull);
      chk("R6 ioOut per-clock", ioOut, expIo);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finishUp();
    end
  end

  // ---------------- master tasks ----------------
  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  // gmode: 0 none, 1 SCL low pulse in high, 2 SCL high pulse in low, 3 SDA pulse in high
  task automatic sendBit(input logic b, input int gmode, output logic seen);
    mSda = b;
    if (gmode == 2) begin
      waitClk(3); gScl = 1; waitClk(2); gScl = 0; waitClk(H/2 - 5);
    end else waitClk(H/2);
    mScl = 1;
    waitClk(H/2);
    seen = busSda;
    if (gmode == 1) begin gScl = 1; waitClk(2); gScl = 0; waitClk(H/2 - 2); end
    else if (gmode == 3) begin gSda = 1; waitClk(2); gSda = 0; waitClk(H/2 - 2); end
    else waitClk(H/2);
    mScl = 0;
    waitClk(H/2);
  endtask

  task automatic startCond();
    mSda = 0; waitClk(H); mScl = 0; waitClk(H/2);
  endtask

  task automatic rstartCond();
    mSda = 1; waitClk(H/2); mScl = 1; waitClk(H/2); mSda = 0; waitClk(H/2);
    mScl = 0; waitClk(H/2);
  endtask

  task automatic stopCond();
    mSda = 0; waitClk(H/2); mScl = 1; waitClk(H/2); mSda = 1; waitClk(H);
  endtask

  task automatic writeByte(input logic [7:0] b, input int gmode, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(b[i], gmode, s);
    sendBit(1'b1, 0, s);
    ack = !s;
  endtask

  task automatic readByte(output logic [7:0] v, input logic ackIt);
    logic s;
    for (int i = 7; i >= 0; i--) begin sendBit(1'b1, 0, s); v[i] = s; end
    sendBit(!ackIt, 0, s);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic ack;
    logic [7:0] v;
    logic s;
    waitClk(5);
    rst = 0;
    waitClk(3);
    chk("R1 reset pull", sdaPullLow, 0);
    chk("R1 reset ioOut", ioOut, 8'h00);

    // R5 / R6: plain write
    startCond();
    writeByte({ADDR, 1'b0}, 0, ack); chk("R5 write address ack", ack, 1);
    writeByte(8'hA5, 0, ack);        chk("R6 data ack", ack, 1);
    stopCond();
    chk("R6 ioOut after write", ioOut, 8'hA5);

    // R7 / R8: read, ack, read, nack, read again released
    startCond();
    writeByte({ADDR, 1'b1}, 0, ack); chk("R5 read address ack", ack, 1);
    readByte(v, 1'b1); chk("R7 first read byte", v, 8'hA5);
    readByte(v, 1'b1); chk("R7 second read byte", v, 8'hA5);
    readByte(v, 1'b0); chk("R7 byte before nack", v, 8'hA5);
    readByte(v, 1'b0); chk("R8 released after nack", v, 8'hFF);
    stopCond();

    // R4: address mismatch in the LSB and in the MSB
    startCond();
    writeByte({7'h26, 1'b0}, 0, ack); chk("R4 lsb mismatch no ack", ack, 0);
    writeByte(8'h3C, 0, ack);         chk("R4 no data ack", ack, 0);
    stopCond();
    startCond();
    writeByte({7'h67, 1'b0}, 0, ack); chk("R4 msb mismatch no ack", ack, 0);
    writeByte(8'h3C, 0, ack);
    stopCond();
    chk("R4 register untouched", ioOut, 8'hA5);

    // R3: most significant bit first
    startCond();
    writeByte({ADDR, 1'b0}, 0, ack);
    writeByte(8'h80, 0, ack);
    stopCond();
    chk("R3 msb first", ioOut, 8'h80);

    // R6 / R9: multi-byte write, repeated start, read back
    startCond();
    writeByte({ADDR, 1'b0}, 0, ack);
    writeByte(8'h11, 0, ack);
    chk("R6 first of two", ioOut, 8'h11);
    writeByte(8'h22, 0, ack); chk("R6 second ack", ack, 1);
    rstartCond();
    writeByte({ADDR, 1'b1}, 0, ack); chk("R9 ack after repeated start", ack, 1);
    readByte(v, 1'b0); chk("R9 read after repeated start", v, 8'h22);
    stopCond();

    // R9: STOP in the middle of the address byte
    startCond();
    sendBit(1'b0, 0, s); sendBit(1'b1, 0, s); sendBit(1'b0, 0, s);
    stopCond();
    startCond();
    writeByte({ADDR, 1'b0}, 0, ack); chk("R9 ack after aborted frame", ack, 1);
    writeByte(8'h5A, 0, ack);
    stopCond();
    chk("R9 write after aborted frame", ioOut, 8'h5A);

    // R2: short pulses on both lines in every bit
    startCond();
    writeByte({ADDR, 1'b0}, 1, ack); chk("R2 ack with SCL dips", ack, 1);
    writeByte(8'hC3, 2, ack);        chk("R2 ack with SCL spikes", ack, 1);
    writeByte(8'h96, 3, ack);        chk("R2 ack with SDA pulses", ack, 1);
    stopCond();
    chk("R2 glitches ignored", ioOut, 8'h96);

    waitClk(10);
    chk("R1 idle released", sdaPullLow, 0);
    finishUp();
  end
endmodule